// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in test of a dot-matrix character display controller. A single start pulse from the register block opens a fixed test window of 2^WIN_LOG2 clock cycles (262,144 by default). In the first half of the window the block walks every row of every glyph in the character font ROM through an external read port. It sums the returned row patterns into a 16-bit checksum. In the second half it takes over the LED matrix. It first shows a checkerboard of lit dots for a quarter of the window, then the complementary checkerboard for the last quarter.

When the window closes, the block compares the checksum with a constant given by a parameter and holds the outcome on a result bit. For one cycle it then pulses a set of re-initialisation strobes toward the register block. These strobes blank the character store, clear the per-character flash attributes and set the custom-glyph address register to all ones. The same cycle carries the value to load into the control word: all zeros except the result bit at position 5, so the start bit at position 6 clears itself. While busy is high, the host must not access the display.

Top module: `selftest_seq`

## Requirements
- R1: A start pulse sampled while idle raises busy in the next cycle, and busy then stays high for exactly 2^WIN_LOG2 consecutive cycles.
- R2: A start pulse that arrives while busy is high has no effect: the window length, the read sequence and the result are the same as in an undisturbed run.
- R3: Starting in the first busy cycle, the block issues exactly 7 × 128 = 896 ROM reads, one per cycle. The order is code-major: rows 0 to 6 of code 0, then rows 0 to 6 of code 1, and so on up to code 127. No read is issued outside those 896 cycles.
- R4: The 5-bit ROM data that returns in the cycle after each read is zero-extended and summed modulo 2^16. The test passes if and only if this sum equals EXP_SUM.
- R5: The pattern override is off while idle and during the first half of the window (busy cycles 0 to 2^(WIN_LOG2-1)-1). It is on for the rest of the window.
- R6: Dot index r*5+c (row r 0..6, column c 0..4) is lit when r+c is even during busy cycles [2^(WIN_LOG2-1), 3·2^(WIN_LOG2-2)). It is lit when r+c is odd from there to the end of the window.
- R7: In the first cycle after busy falls, the four re-initialisation strobes are high together for exactly one cycle. In that cycle the control load value is 8'h20 on pass and 8'h00 on fail, so bit 6 is always 0.
- R8: The result bit is 0 after reset, takes the test outcome in the cycle the strobes fire, and holds that value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Test start pulse (control bit 6 written as 1) |
| busy_o | output | 1 | Test window active; display must not be accessed |
| rom_rd_o | output | 1 | Font ROM read request |
| rom_code_o | output | 7 | Font ROM character code |
| rom_row_o | output | 3 | Font ROM row within the glyph |
| rom_data_i | input | 5 | Font ROM row data, valid one cycle after the read |
| ovr_en_o | output | 1 | LED matrix pattern override active |
| ovr_dots_o | output | 35 | Override dots, index row*5+column |
| pass_o | output | 1 | Test result (1 = checksum matched) |
| chr_blank_stb_o | output | 1 | Fill the character store with spaces |
| flash_clr_stb_o | output | 1 | Clear all flash attributes |
| udc_ones_stb_o | output | 1 | Set the custom-glyph address register to all ones |
| ctrl_load_stb_o | output | 1 | Load ctrl_load_val_o into the control word |
| ctrl_load_val_o | output | 8 | Control word value to load |

## Verification
A wrong window counter shows up at once in the busy length and in where the pattern phases fall. Each is visible within a single run. A broken read walker shows on the first wrong ROM address, or on a read issued after the 896th. A missed or double-counted data beat only surfaces at completion, as a wrong result bit and control load value. To catch it, the bench runs once with a matching ROM and once with a single corrupted row. A stuck re-initialisation path is seen in the single cycle after busy falls.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SUM  = 2'd1,
    PH_CHK  = 2'd2,
    PH_INV  = 2'd3
  } st_phase_e;

  localparam int RESULT_BIT = 5;
endpackage

// File: rtl/selftest_timer.sv
module selftest_timer
  import selftest_pkg::*;
#(
  parameter int WIN_LOG2 = 18
) (
  input  logic                clk,
  input  logic                rs_n,
  input  logic                go_i,
  output logic                busy_o,
  output logic                last_o,
  output logic [WIN_LOG2-1:0] cnt_o,
  output st_phase_e           phase_o
);
  localparam logic [WIN_LOG2-1:0] CNT_MAX = '1;

  logic                busy_q, busy_n;
  logic [WIN_LOG2-1:0] cnt_q, cnt_n;
  logic                cnt_en;

  assign cnt_en = go_i | busy_q;
  assign last_o = busy_q & (cnt_q == CNT_MAX);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (go_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_MAX) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  always_comb begin
    if (!busy_q)                phase_o = PH_IDLE;
    else if (!cnt_q[WIN_LOG2-1]) phase_o = PH_SUM;
    else if (!cnt_q[WIN_LOG2-2]) phase_o = PH_CHK;
    else                         phase_o = PH_INV;
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  // R1: the counter restarts only from idle
  a_r1_go_from_idle: assert property (@(posedge clk) disable iff (!rs_n)
    go_i |-> !busy_q);
  // R1: busy falls only after the final count
  a_r1_fall_at_end: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(busy_q) |-> $past(cnt_q) == CNT_MAX);
endmodule

// File: rtl/selftest_rom_sum.sv
module selftest_rom_sum #(
  parameter int CODES  = 128,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int SUM_W  = 16,
  parameter int CODE_W = $clog2(CODES),
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rs_n,
  input  logic              go_i,
  output logic              rd_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ROW_W-1:0]  row_o,
  input  logic [COLS-1:0]   data_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(CODES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic              run_q, run_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic              vld_q, fin_q, fin_n;
  logic [SUM_W-1:0]  sum_q, sum_n;
  logic              done_q, done_n;
  logic              is_last;

  assign is_last = (code_q == CODE_LAST) && (row_q == ROW_LAST);

  always_comb begin
    run_n  = run_q;
    code_n = code_q;
    row_n  = row_q;
    fin_n  = 1'b0;
    sum_n  = sum_q;
    done_n = done_q;
    if (go_i) begin
      run_n  = 1'b1;
      code_n = '0;
      row_n  = '0;
      sum_n  = '0;
      done_n = 1'b0;
    end else begin
      if (run_q) begin
        fin_n = is_last;
        if (is_last) begin
          run_n = 1'b0;
        end else if (row_q == ROW_LAST) begin
          row_n  = '0;
          code_n = code_q + 1'b1;
        end else begin
          row_n = row_q + 1'b1;
        end
      end
      if (vld_q) begin
        sum_n = sum_q + SUM_W'(data_i);
        if (fin_q) done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      run_q  <= 1'b0;
      code_q <= '0;
      row_q  <= '0;
      vld_q  <= 1'b0;
      fin_q  <= 1'b0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q <= run_q & ~go_i;
      fin_q <= fin_n;
      if (go_i | run_q) begin
        run_q  <= run_n;
        code_q <= code_n;
        row_q  <= row_n;
      end
      if (go_i | vld_q) begin
        sum_q  <= sum_n;
        done_q <= done_n;
      end
    end
  end

  assign rd_o   = run_q;
  assign code_o = code_q;
  assign row_o  = row_q;
  assign sum_o  = sum_q;
  assign done_o = done_q;

  // R3: the row index never leaves the glyph
  a_r3_row_range: assert property (@(posedge clk) disable iff (!rs_n)
    rd_o |-> row_q <= ROW_LAST);
  // R4: every read is followed by one accumulation beat
  a_r4_beat_follows_read: assert property (@(posedge clk) disable iff (!rs_n)
    rd_o && !go_i |=> vld_q);
  // R4: the sum is frozen once the walk is done
  a_r4_sum_frozen: assert property (@(posedge clk) disable iff (!rs_n)
    done_q && !go_i |=> $stable(sum_q));
endmodule

// File: rtl/selftest_pattern.sv
module selftest_pattern
  import selftest_pkg::*;
#(
  parameter int ROWS = 7,
  parameter int COLS = 5,
  parameter int DOTS = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rs_n,
  input  st_phase_e       phase_i,
  output logic            en_o,
  output logic [DOTS-1:0] dots_o
);
  localparam int EVEN_DOTS = (DOTS + 1) / 2;
  localparam int ODD_DOTS  = DOTS - EVEN_DOTS;

  logic inv;

  assign en_o = (phase_i == PH_CHK) || (phase_i == PH_INV);
  assign inv  = (phase_i == PH_INV);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam bit EVEN = ((r + c) % 2) == 0;
      assign dots_o[r*COLS+c] = en_o && (EVEN != inv);
    end
  end

  // R6: lit-dot counts of the two patterns
  a_r6_checker_count: assert property (@(posedge clk) disable iff (!rs_n)
    phase_i == PH_CHK |-> $countones(dots_o) == EVEN_DOTS);
  a_r6_inverse_count: assert property (@(posedge clk) disable iff (!rs_n)
    phase_i == PH_INV |-> $countones(dots_o) == ODD_DOTS);
  // R6: checker hands over directly to inverse
  a_r6_phase_order: assert property (@(posedge clk) disable iff (!rs_n)
    phase_i == PH_INV |-> $past(phase_i) == PH_CHK || $past(phase_i) == PH_INV);
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int                WIN_LOG2 = 18,
  parameter int                CODES    = 128,
  parameter int                ROWS     = 7,
  parameter int                COLS     = 5,
  parameter int                SUM_W    = 16,
  parameter logic [SUM_W-1:0]  EXP_SUM  = 16'h3A5C,
  localparam int               CODE_W   = $clog2(CODES),
  localparam int               ROW_W    = $clog2(ROWS),
  localparam int               DOTS     = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              rom_rd_o,
  output logic [CODE_W-1:0] rom_code_o,
  output logic [ROW_W-1:0]  rom_row_o,
  input  logic [COLS-1:0]   rom_data_i,
  output logic              ovr_en_o,
  output logic [DOTS-1:0]   ovr_dots_o,
  output logic              pass_o,
  output logic              chr_blank_stb_o,
  output logic              flash_clr_stb_o,
  output logic              udc_ones_stb_o,
  output logic              ctrl_load_stb_o,
  output logic [7:0]        ctrl_load_val_o
);
  localparam logic [WIN_LOG2-1:0] HALF = WIN_LOG2'(1) << (WIN_LOG2 - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  logic                go, last, sum_done;
  logic [WIN_LOG2-1:0] cnt;
  logic [SUM_W-1:0]    sum;
  st_phase_e           phase;

  assign go = start_i & ~busy_o;

  selftest_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(clk), .rs_n(rs_n), .go_i(go),
    .busy_o(busy_o), .last_o(last), .cnt_o(cnt), .phase_o(phase)
  );

  selftest_rom_sum #(
    .CODES(CODES), .ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W),
    .CODE_W(CODE_W), .ROW_W(ROW_W)
  ) u_sum (
    .clk(clk), .rs_n(rs_n), .go_i(go),
    .rd_o(rom_rd_o), .code_o(rom_code_o), .row_o(rom_row_o),
    .data_i(rom_data_i), .sum_o(sum), .done_o(sum_done)
  );

  selftest_pattern #(.ROWS(ROWS), .COLS(COLS)) u_pat (
    .clk(clk), .rs_n(rs_n), .phase_i(phase),
    .en_o(ovr_en_o), .dots_o(ovr_dots_o)
  );

  // completion: result and re-initialisation strobes
  logic       match;
  logic       pass_q, pass_n;
  logic       stb_q;
  logic [7:0] cval_q, cval_n;

  assign match = sum_done && (sum == EXP_SUM);

  always_comb begin
    pass_n = pass_q;
    cval_n = 8'h00;
    if (last) begin
      pass_n             = match;
      cval_n[RESULT_BIT] = match;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      pass_q <= 1'b0;
      stb_q  <= 1'b0;
      cval_q <= 8'h00;
    end else begin
      stb_q  <= last;
      cval_q <= cval_n;
      if (last) pass_q <= pass_n;
    end
  end

  assign pass_o          = pass_q;
  assign chr_blank_stb_o = stb_q;
  assign flash_clr_stb_o = stb_q;
  assign udc_ones_stb_o  = stb_q;
  assign ctrl_load_stb_o = stb_q;
  assign ctrl_load_val_o = cval_q;

  // R2: a start during the window does not disturb the count
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rs_n)
    busy_o && start_i && !last |=> busy_o && cnt == $past(cnt) + 1'b1);
  // R3: reads only occur in the first half of the window
  a_r3_reads_early: assert property (@(posedge clk) disable iff (!rs_n)
    rom_rd_o |-> busy_o && cnt < HALF);
  // R4: checksum walk finished before the pattern half starts
  a_r4_sum_ready: assert property (@(posedge clk) disable iff (!rs_n)
    busy_o && cnt == HALF |-> sum_done);
  // R5: override only in the second half of a window
  a_r5_no_early_override: assert property (@(posedge clk) disable iff (!rs_n)
    ovr_en_o |-> busy_o && cnt >= HALF);
  // R7: strobe lasts one cycle and follows the window end
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rs_n)
    ctrl_load_stb_o |=> !ctrl_load_stb_o);
  a_r7_strobe_after_busy: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(busy_o) |-> ctrl_load_stb_o);
  a_r7_value_fields: assert property (@(posedge clk) disable iff (!rs_n)
    ctrl_load_stb_o |-> ctrl_load_val_o[7:6] == 2'b00 &&
                        ctrl_load_val_o[RESULT_BIT] == pass_o);
  // R8: result changes only together with the strobe
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rs_n)
    !ctrl_load_stb_o |-> $stable(pass_o));
endmodule

// File: tb/test_selftest_seq.sv
module test_selftest_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WL    = 11;
  localparam int TOTAL = 1 << WL;
  localparam int HALF  = TOTAL / 2;
  localparam int Q3    = 3 * TOTAL / 4;
  localparam int NRD   = 7 * 128;

  function automatic logic [4:0] rom_f(input int code, input int row);
    return 5'((code * 3 + row * 5 + (code >> 2)) & 31);
  endfunction

  function automatic logic [15:0] exp_sum_f();
    logic [15:0] s = '0;
    for (int c = 0; c < 128; c++)
      for (int r = 0; r < 7; r++) s = s + 16'(rom_f(c, r));
    return s;
  endfunction

  localparam logic [15:0] EXP = exp_sum_f();

  function automatic logic [34:0] pat_f(input bit inv);
    logic [34:0] p;
    for (int r = 0; r < 7; r++)
      for (int c = 0; c < 5; c++) p[r*5+c] = (((r + c) % 2) == 0) != inv;
    return p;
  endfunction

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic        busy, rom_rd, ovr_en, pass;
  logic [6:0]  rom_code;
  logic [2:0]  rom_row;
  logic [4:0]  rom_q;
  logic [34:0] dots;
  logic        s_chr, s_fl, s_udc, s_ctl;
  logic [7:0]  cval;
  bit          corrupt;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  selftest_seq #(.WIN_LOG2(WL), .EXP_SUM(EXP)) i_selftest_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .rom_rd_o(rom_rd), .rom_code_o(rom_code), .rom_row_o(rom_row),
    .rom_data_i(rom_q), .ovr_en_o(ovr_en), .ovr_dots_o(dots),
    .pass_o(pass), .chr_blank_stb_o(s_chr), .flash_clr_stb_o(s_fl),
    .udc_ones_stb_o(s_udc), .ctrl_load_stb_o(s_ctl), .ctrl_load_val_o(cval)
  );

  // font ROM model: one cycle read latency
  always @(posedge clk)
    if (rom_rd)
      rom_q <= rom_f(int'(rom_code), int'(rom_row)) ^
               ((corrupt && rom_code == 7'd5 && rom_row == 3'd2) ? 5'd1 : 5'd0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one full test window; poke = second start inside the window
  task automatic run_window(input bit bad_rom, input bit poke, input string tag);
    int busy_err = 0, rd_err = 0, rd_cnt = 0, early = 0, pat_err = 0, stb_err = 0;
    logic [7:0] cv = 8'hxx;
    corrupt = bad_rom;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int s = 0; s <= TOTAL + 1; s++) begin
      if (s < TOTAL) begin if (!busy) busy_err++; end
      else if (busy) busy_err++;
      if (rom_rd) rd_cnt++;
      if (s < NRD) begin
        if (!rom_rd || rom_code != 7'(s / 7) || rom_row != 3'(s % 7)) rd_err++;
      end else if (rom_rd) rd_err++;
      if (s < HALF || s >= TOTAL) begin if (ovr_en) early++; end
      else if (!ovr_en || dots != pat_f(s >= Q3)) pat_err++;
      if (s == TOTAL) begin
        if (!(s_chr && s_fl && s_udc && s_ctl)) stb_err++;
        cv = cval;
      end else if (s_chr || s_fl || s_udc || s_ctl) stb_err++;
      if (poke && s == 100) start = 1'b1;
      if (poke && s == 101) start = 1'b0;
      @(negedge clk);
    end
    chk(busy_err == 0, poke ? "R2 busy length with extra start" : "R1 busy length", busy_err, 0);
    chk(rd_cnt == NRD, poke ? "R2 read count with extra start" : "R3 read count", rd_cnt, NRD);
    chk(rd_err == 0, "R3 read address order", rd_err, 0);
    chk(early == 0, "R5 override outside second half", early, 0);
    chk(pat_err == 0, "R6 checker/inverse dots", pat_err, 0);
    chk(stb_err == 0, "R7 strobe timing", stb_err, 0);
    chk(cv == (bad_rom ? 8'h00 : 8'h20), "R7 control load value", int'(cv), bad_rom ? 0 : 32);
    chk(pass == !bad_rom, "R4 checksum result", int'(pass), int'(!bad_rom));
    repeat (20) @(negedge clk);
    chk(pass == !bad_rom, "R8 result held after completion", int'(pass), int'(!bad_rom));
    $display("[TB] window done: %s", tag);
  endtask

  task automatic reset_check();
    rst_n = 1'b0; start = 1'b0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1 reset busy", int'(busy), 0);
    chk(!pass, "R8 reset result", int'(pass), 0);
    chk(!ovr_en, "R5 reset override", int'(ovr_en), 0);
    chk(!(s_chr || s_fl || s_udc || s_ctl), "R7 reset strobes", int'(s_ctl), 0);
    chk(!rom_rd, "R3 reset read", int'(rom_rd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    reset_check();
    run_window(1'b0, 1'b0, "good ROM");
    run_window(1'b1, 1'b0, "corrupted ROM");
    run_window(1'b0, 1'b1, "start while busy");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule